// File: doc/BRIEF.md
# Multi-Queue Almost-Empty Flag Tracker

This block keeps an occupancy count for each of four queues that share one storage array. It compares every count with that queue's own almost-empty threshold and reports the result in two forms. A four-bit status bus carries one flag per queue. A single registered flag carries the status of the queue that the read port has selected. The storage itself, the serial programming path and any clock-domain crossing are outside this block. Write strobes arrive already in the read clock domain.

Software or a programming sequencer writes the per-queue threshold and depth through a small configuration port. The threshold can be user-supplied or taken from one of two built-in defaults. The read side picks a queue with an address and an address-enable. The new selection reaches the flag output on the second clock edge after it is sampled. Status changes pass through two register stages, so reads and writes show up on the flag two edges after the strobe. Queues that are not selected keep their status current on the bus.

Top module: `mq_ae_tracker`

## Requirements
- R1: A write strobe `wr_en[q]` sampled at an edge raises queue q's count by one. A sampled `rd_en` lowers the count of the active read queue by one.
- R2: Flags are active-low. Bus bit q (bit index equals queue number) is 0 while queue q's count is less than or equal to its threshold, and 1 otherwise. The bit follows a count change one edge after that change.
- R3: A read or write strobe sampled at edge E changes `ae_flag_n` at edge E+2, not before.
- R4: `rd_addr` sampled with `rd_addr_en` high at edge S makes that queue the active read queue from edge S+1. `ae_flag_n` shows the new queue's status from edge S+2.
- R5: Queues that are not the active read queue keep counting writes, and their bits on `ae_bus` keep updating.
- R6: With `cfg_we` high, `cfg_depth` and the threshold of queue `cfg_q` are loaded at the edge. A user threshold (`cfg_use_default`=0) above the new depth is clamped to the depth.
- R7: With `cfg_use_default`=1 the threshold is 8 when `cfg_def_sel`=0 and 128 when `cfg_def_sel`=1. The value is clamped to the depth.
- R8: A read of an empty queue (count 0) is ignored, and so is a write to a full queue (count at or above its depth). The count is unchanged in both cases.
- R9: A read and a write to the same queue at the same edge leave its count unchanged.
- R10: A synchronous reset (`rst` high) clears all counts, drives `ae_bus` and `ae_flag_n` to 0 and selects queue 0. After reset every depth is 1023 and every threshold is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 4 | Per-queue write strobe, bit q for queue q |
| rd_en | input | 1 | Read strobe for the active read queue |
| rd_addr | input | 2 | Read queue address |
| rd_addr_en | input | 1 | Samples `rd_addr` as a new selection |
| cfg_we | input | 1 | Configuration write enable |
| cfg_q | input | 2 | Queue being configured |
| cfg_offset | input | 10 | User almost-empty threshold |
| cfg_depth | input | 10 | Queue depth |
| cfg_use_default | input | 1 | Use a built-in threshold instead of `cfg_offset` |
| cfg_def_sel | input | 1 | Built-in threshold: 0 gives 8, 1 gives 128 |
| ae_flag_n | output | 1 | Almost-empty flag of the selected queue, active low |
| ae_bus | output | 4 | Almost-empty flag of every queue, active low |

## Verification
The hardest case to reach is a queue switch that lands while the new queue's status is still moving through the two register stages. A related case is a queue that is full because its depth was lowered below its count. A directed sequence fills a queue that is not selected, switches to it, and samples the flag one edge and two edges after the switch. It then lowers depths below the live counts to exercise the full and clamp paths. Random traffic follows: a small random depth makes queues run full and empty often, and selections and reconfigurations arrive in the middle of reads and writes. A bench model, built from the requirements, checks every cycle of that traffic.

// File: rtl/mqae_pkg.sv
package mqae_pkg;

    typedef enum logic [0:0] {
        SEL_IDLE    = 1'b0,
        SEL_PENDING = 1'b1
    } sel_state_e;

endpackage

// File: rtl/mqae_cfg_regs.sv
module mqae_cfg_regs #(
    parameter int NUM_Q  = 4,
    parameter int CNT_W  = 10,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128,
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [QW-1:0]                 cfg_q,
    input  logic [CNT_W-1:0]              cfg_offset,
    input  logic [CNT_W-1:0]              cfg_depth,
    input  logic                          cfg_use_default,
    input  logic                          cfg_def_sel,
    output logic [NUM_Q-1:0][CNT_W-1:0]   thr_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]   depth_o
);

    localparam logic [CNT_W-1:0] DEF_LO_V  = CNT_W'(DEF_LO);
    localparam logic [CNT_W-1:0] DEF_HI_V  = CNT_W'(DEF_HI);
    localparam logic [CNT_W-1:0] MAX_DEPTH = {CNT_W{1'b1}};

    logic [CNT_W-1:0] raw_thr;
    logic [CNT_W-1:0] new_thr;

    always_comb begin
        if (cfg_use_default) begin
            raw_thr = cfg_def_sel ? DEF_HI_V : DEF_LO_V;
        end else begin
            raw_thr = cfg_offset;
        end
        new_thr = (raw_thr > cfg_depth) ? cfg_depth : raw_thr;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_o[q]   <= DEF_LO_V;
                depth_o[q] <= MAX_DEPTH;
            end else if (cfg_we && (cfg_q == QW'(q))) begin
                thr_o[q]   <= new_thr;
                depth_o[q] <= cfg_depth;
            end
        end
    end

endmodule

// File: rtl/mqae_queue_counter.sv
module mqae_queue_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ae_n_o
);

    logic is_full;
    logic is_empty;

    always_comb begin
        is_full  = (cnt_o >= depth);
        is_empty = (cnt_o == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (wr && !rd && !is_full) begin
            cnt_o <= cnt_o + 1'b1;
        end else if (rd && !wr && !is_empty) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    // first status stage: registered compare of the live count
    always_ff @(posedge clk) begin
        if (rst) begin
            ae_n_o <= 1'b0;
        end else begin
            ae_n_o <= (cnt_o > thr);
        end
    end

endmodule

// File: rtl/mqae_read_select.sv
module mqae_read_select
    import mqae_pkg::*;
#(
    parameter int NUM_Q = 4,
    localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_en,
    input  logic [QW-1:0] addr,
    output logic [QW-1:0] act_q
);

    sel_state_e    state_q;
    sel_state_e    state_d;
    logic [QW-1:0] pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE:    state_d = addr_en ? SEL_PENDING : SEL_IDLE;
            SEL_PENDING: state_d = addr_en ? SEL_PENDING : SEL_IDLE;
            default:     state_d = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (addr_en) begin
                pend_q <= addr;
            end
            if (state_q == SEL_PENDING) begin
                act_q <= pend_q;
            end
        end
    end

endmodule

// File: rtl/mq_ae_tracker.sv
module mq_ae_tracker #(
    parameter int NUM_Q  = 4,
    parameter int CNT_W  = 10,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128,
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] wr_en,
    input  logic             rd_en,
    input  logic [QW-1:0]    rd_addr,
    input  logic             rd_addr_en,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_q,
    input  logic [CNT_W-1:0] cfg_offset,
    input  logic [CNT_W-1:0] cfg_depth,
    input  logic             cfg_use_default,
    input  logic             cfg_def_sel,
    output logic             ae_flag_n,
    output logic [NUM_Q-1:0] ae_bus
);

    logic [NUM_Q-1:0][CNT_W-1:0] thr_all;
    logic [NUM_Q-1:0][CNT_W-1:0] depth_all;
    logic [NUM_Q-1:0][CNT_W-1:0] cnt_all;
    logic [QW-1:0]               act_q;

    mqae_cfg_regs #(
        .NUM_Q (NUM_Q),
        .CNT_W (CNT_W),
        .DEF_LO(DEF_LO),
        .DEF_HI(DEF_HI)
    ) u_cfg (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_q          (cfg_q),
        .cfg_offset     (cfg_offset),
        .cfg_depth      (cfg_depth),
        .cfg_use_default(cfg_use_default),
        .cfg_def_sel    (cfg_def_sel),
        .thr_o          (thr_all),
        .depth_o        (depth_all)
    );

    mqae_read_select #(
        .NUM_Q(NUM_Q)
    ) u_sel (
        .clk    (clk),
        .rst    (rst),
        .addr_en(rd_addr_en),
        .addr   (rd_addr),
        .act_q  (act_q)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_cnt
        logic rd_this;
        assign rd_this = rd_en && (act_q == QW'(q));

        mqae_queue_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_en[q]),
            .rd    (rd_this),
            .depth (depth_all[q]),
            .thr   (thr_all[q]),
            .cnt_o (cnt_all[q]),
            .ae_n_o(ae_bus[q])
        );
    end

    // second status stage: pick the active queue's flag
    always_ff @(posedge clk) begin
        if (rst) begin
            ae_flag_n <= 1'b0;
        end else begin
            ae_flag_n <= ae_bus[act_q];
        end
    end

endmodule

// File: rtl/mq_ae_tracker_chk.sv
module mq_ae_tracker_chk #(
    parameter int NUM_Q = 4,
    parameter int CNT_W = 10,
    localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_Q-1:0]            wr_en,
    input logic                        rd_en,
    input logic [QW-1:0]               rd_addr,
    input logic                        rd_addr_en,
    input logic                        ae_flag_n,
    input logic [NUM_Q-1:0]            ae_bus,
    input logic [NUM_Q-1:0][CNT_W-1:0] cnt,
    input logic [NUM_Q-1:0][CNT_W-1:0] thr,
    input logic [QW-1:0]               act_q
);

    logic [1:0] live = 2'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 2'd0;
        end else if (live != 2'd3) begin
            live <= live + 2'd1;
        end
    end

    AST_FLAG_STAGE: assert property (@(posedge clk) disable iff (rst || live < 2'd2)
        ae_flag_n == $past(ae_bus[act_q])); // R3

    AST_SWITCH_LATENCY: assert property (@(posedge clk) disable iff (rst || live < 2'd3)
        ($past(rd_addr_en, 2) && !$past(rd_addr_en)) |-> (act_q == $past(rd_addr, 2))); // R4

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (rst || live < 2'd2)
            ae_bus[q] == $past(cnt[q] > thr[q])); // R2

        AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (cnt[q] == '0 && !wr_en[q]) |=> (cnt[q] == '0)); // R8

        AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
            (wr_en[q] && rd_en && act_q == QW'(q)) |=> $stable(cnt[q])); // R9

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!wr_en[q] && !(rd_en && act_q == QW'(q))) |=> $stable(cnt[q])); // R1
    end

endmodule

bind mq_ae_tracker mq_ae_tracker_chk #(
    .NUM_Q(NUM_Q),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_addr_en(rd_addr_en),
    .ae_flag_n (ae_flag_n),
    .ae_bus    (ae_bus),
    .cnt       (cnt_all),
    .thr       (thr_all),
    .act_q     (act_q)
);

// File: tb/mq_ae_tracker_bench.sv
module mq_ae_tracker_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] wr_en;
    logic       rd_en;
    logic [1:0] rd_addr;
    logic       rd_addr_en;
    logic       cfg_we;
    logic [1:0] cfg_q;
    logic [9:0] cfg_offset;
    logic [9:0] cfg_depth;
    logic       cfg_use_default;
    logic       cfg_def_sel;
    logic       ae_flag_n;
    logic [3:0] ae_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // requirement model
    int m_cnt[4];
    int m_thr[4];
    int m_dep[4];
    bit m_pv;
    int m_pend;
    int m_act;
    bit [3:0] m_bus;
    bit m_flag;

    always #4 clk = ~clk;

    mq_ae_tracker u_mq_ae_tracker (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_addr_en(rd_addr_en), .cfg_we(cfg_we),
        .cfg_q(cfg_q), .cfg_offset(cfg_offset), .cfg_depth(cfg_depth),
        .cfg_use_default(cfg_use_default), .cfg_def_sel(cfg_def_sel),
        .ae_flag_n(ae_flag_n), .ae_bus(ae_bus)
    );

    function automatic int clamp_thr(bit use_def, bit dsel, int off, int dep);
        int raw;
        raw = use_def ? (dsel ? 128 : 8) : off;
        return (raw > dep) ? dep : raw;
    endfunction

    task automatic model_edge();
        bit [3:0] n_bus;
        bit n_flag;
        if (rst) begin
            for (int q = 0; q < 4; q++) begin
                m_cnt[q] = 0; m_thr[q] = 8; m_dep[q] = 1023;
            end
            m_pv = 0; m_pend = 0; m_act = 0; m_bus = '0; m_flag = 0;
            return;
        end
        n_flag = m_bus[m_act];
        for (int q = 0; q < 4; q++) n_bus[q] = (m_cnt[q] > m_thr[q]);
        for (int q = 0; q < 4; q++) begin
            bit w, r;
            w = wr_en[q];
            r = rd_en && (m_act == q);
            if (w && !r && m_cnt[q] < m_dep[q]) m_cnt[q]++;
            else if (r && !w && m_cnt[q] > 0) m_cnt[q]--;
        end
        if (cfg_we) begin
            m_thr[cfg_q] = clamp_thr(cfg_use_default, cfg_def_sel, int'(cfg_offset), int'(cfg_depth));
            m_dep[cfg_q] = int'(cfg_depth);
        end
        if (m_pv) m_act = m_pend;
        if (rd_addr_en) m_pend = int'(rd_addr);
        m_pv = rd_addr_en;
        m_bus = n_bus;
        m_flag = n_flag;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        wr_en = '0; rd_en = 0; rd_addr = '0; rd_addr_en = 0;
        cfg_we = 0; cfg_q = '0; cfg_offset = '0; cfg_depth = '0;
        cfg_use_default = 0; cfg_def_sel = 0;
    endtask

    task automatic idle(int n);
        idle_in();
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(int q, int n);
        for (int i = 0; i < n; i++) begin
            idle_in(); wr_en[q] = 1'b1; tick();
        end
        idle_in();
    endtask

    task automatic do_read(int n);
        for (int i = 0; i < n; i++) begin
            idle_in(); rd_en = 1'b1; tick();
        end
        idle_in();
    endtask

    task automatic do_both(int q, int n);
        for (int i = 0; i < n; i++) begin
            idle_in(); rd_en = 1'b1; wr_en[q] = 1'b1; tick();
        end
        idle_in();
    endtask

    task automatic select(int q);
        idle_in(); rd_addr = 2'(q); rd_addr_en = 1'b1; tick();
        idle_in();
    endtask

    task automatic config_q(int q, int off, int dep, bit use_def, bit dsel);
        idle_in();
        cfg_we = 1'b1; cfg_q = 2'(q); cfg_offset = 10'(off); cfg_depth = 10'(dep);
        cfg_use_default = use_def; cfg_def_sel = dsel;
        tick();
        idle_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_in();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        @(negedge clk);
        check("R10 bus after reset", int'(ae_bus), 0);
        check("R10 flag after reset", int'(ae_flag_n), 0);

        // queue 0: threshold 2, depth 10; timing of the two stages
        config_q(0, 2, 10, 0, 0);
        do_write(0, 3);
        check("R2 bus not yet updated", int'(ae_bus[0]), 0);
        idle(1);
        check("R2 bus bit0 high above threshold", int'(ae_bus[0]), 1);
        check("R3 flag still low one edge later", int'(ae_flag_n), 0);
        idle(1);
        check("R3 flag high two edges after write (R10 queue 0 selected)", int'(ae_flag_n), 1);
        do_read(1);
        idle(1);
        check("R1 read lowers count to threshold", int'(ae_bus[0]), 0);
        check("R3 flag holds one edge after read", int'(ae_flag_n), 1);
        idle(1);
        check("R3 flag low two edges after read", int'(ae_flag_n), 0);

        // background update of queue 2 (reset threshold 8)
        do_write(2, 9);
        idle(2);
        check("R5 unselected queue bit updates", int'(ae_bus), 4);
        check("R5 flag keeps selected queue", int'(ae_flag_n), 0);

        // switch to queue 2
        select(2);
        idle(1);
        check("R4 flag old queue one edge after select", int'(ae_flag_n), 0);
        idle(1);
        check("R4 flag new queue two edges after select", int'(ae_flag_n), 1);
        do_read(1);
        idle(2);
        check("R1 read hits new active queue", int'(ae_bus[2]), 0);
        check("R1 flag follows read on new queue", int'(ae_flag_n), 0);

        // empty read ignored on queue 1
        config_q(1, 0, 1023, 0, 0);
        select(1);
        idle(2);
        do_read(3);
        do_write(1, 1);
        do_read(1);
        idle(2);
        check("R8 read of empty queue ignored", int'(ae_bus[1]), 0);

        // full write ignored on queue 3
        config_q(3, 2, 3, 0, 0);
        do_write(3, 5);
        select(3);
        idle(2);
        do_read(1);
        idle(2);
        check("R8 write to full queue ignored", int'(ae_bus[3]), 0);

        // read and write together
        do_both(3, 3);
        idle(2);
        check("R9 read plus write keeps count", int'(ae_bus[3]), 0);
        do_write(3, 1);
        idle(2);
        check("R9 count unchanged before single write", int'(ae_bus[3]), 1);

        // default thresholds
        config_q(1, 0, 1023, 1, 1);
        do_write(1, 128);
        idle(2);
        check("R7 default 128 at boundary", int'(ae_bus[1]), 0);
        do_write(1, 1);
        idle(2);
        check("R7 default 128 crossed", int'(ae_bus[1]), 1);
        config_q(0, 0, 10, 1, 0);
        do_write(0, 6);
        idle(2);
        check("R7 default 8 at boundary", int'(ae_bus[0]), 0);
        do_write(0, 1);
        idle(2);
        check("R7 default 8 crossed", int'(ae_bus[0]), 1);

        // clamp
        config_q(0, 50, 5, 0, 0);
        idle(2);
        check("R6 threshold clamped to depth", int'(ae_bus[0]), 1);
        config_q(3, 3, 3, 0, 0);
        idle(2);
        check("R6 threshold equal to depth", int'(ae_bus[3]), 0);

        // directed values agree with model before random phase
        check("R5 model bus agrees", int'(ae_bus), int'(m_bus));
        check("R4 model flag agrees", int'(ae_flag_n), int'(m_flag));

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            idle_in();
            wr_en = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            rd_en = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 9) == 0) begin
                rd_addr_en = 1'b1;
                rd_addr = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 49) == 0) begin
                int dep;
                dep = $urandom_range(2, 40);
                cfg_we = 1'b1;
                cfg_q = 2'($urandom_range(0, 3));
                cfg_depth = 10'(dep);
                cfg_offset = 10'($urandom_range(0, dep + 5));
                cfg_use_default = ($urandom_range(0, 4) == 0);
                cfg_def_sel = ($urandom_range(0, 1) == 1);
            end
            tick();
            check("R5 random bus", int'(ae_bus), int'(m_bus));
            check("R4 random flag", int'(ae_flag_n), int'(m_flag));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule